// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where the instruction stream goes after the current instruction. It receives an operation that has already been decoded, plus the current program counter, two register operands, the FP comparison flag and the two immediate offset fields. From these it evaluates the branch condition and forms the target address. It returns the next program counter, a taken flag and, for the linking jumps, a write request that puts the return address into the link register.

Every PC-relative address is formed from the sequential address PC+4. Results are registered, so the outputs for an operation presented in one cycle appear after the next rising clock edge. The block does not fetch, predict, vector exceptions or decode instructions.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `out_valid`, `taken` and `link_we` at 0.
- R2: An operation presented with `in_valid` high produces its results on the outputs after the next rising edge, and `out_valid` is 1 in that cycle.
- R3: Code 0 (sequential) gives `next_pc` = pc+4 and `taken` = 0. A conditional branch whose condition is false also gives pc+4 and `taken` = 0.
- R4: Code 1 branches when `rs_val` equals zero. Code 2 branches when `rs_val` is not zero.
- R5: Code 3 branches when `rs_val` equals `rt_val`. Code 4 branches when they differ.
- R6: Code 5 branches when `fp_cond` is 1. Code 6 branches when `fp_cond` is 0.
- R7: The target of a taken branch is pc+4 plus the 16-bit `boff`, sign-extended and shifted left by 2. `taken` is then 1.
- R8: Code 7 is a direct jump. Its target keeps bits 63..28 of pc+4, with `joff` in bits 27..2 and zeros in bits 1..0. `taken` = 1.
- R9: Code 8 is a register jump. It gives `next_pc` = `rs_val` and `taken` = 1.
- R10: Code 9 jumps like code 7 and code 10 jumps like code 8. Both also give `link_we` = 1, `link_idx` = 31 and `link_val` = pc+4. Every other code gives `link_we` = 0.
- R11: With `in_valid` low, the next cycle shows `out_valid` = 0 and `link_we` = 0.
- R12: The unused codes 11 to 15 behave as code 0: `next_pc` = pc+4, with `taken` and `link_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Decoded control operation code |
| pc | input | 64 | Current program counter |
| rs_val | input | 64 | First register operand (test value or jump target) |
| rt_val | input | 64 | Second register operand |
| fp_cond | input | 1 | FP status comparison bit |
| boff | input | 16 | Branch offset in instructions |
| joff | input | 26 | Direct jump field in instructions |
| out_valid | output | 1 | Registered result valid |
| next_pc | output | 64 | Next program counter |
| taken | output | 1 | Control transfer taken |
| link_we | output | 1 | Write request for the link register |
| link_idx | output | 5 | Link register index |
| link_val | output | 64 | Return address to link |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath, a 16-bit branch field, a 26-bit jump field and link register 31. With these values, random program counters and offsets reach targets that wrap across the 28-bit jump region and across the top of the 64-bit address space. Negative branch offsets reach below pc+4. Directed cases add equal and zero operands, which random data would rarely produce. They also cover the extreme offset values and the unused operation codes.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SEQ    = 4'd0,
    OP_BZERO  = 4'd1,
    OP_BNZERO = 4'd2,
    OP_BSAME  = 4'd3,
    OP_BDIFF  = 4'd4,
    OP_BFTRUE = 4'd5,
    OP_BFFALS = 4'd6,
    OP_JDIR   = 4'd7,
    OP_JREG   = 4'd8,
    OP_LDIR   = 4'd9,
    OP_LREG   = 4'd10
  } ctl_op_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_DIR = 2'd2,
    SRC_REG = 2'd3
  } tgt_src_e;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic            fp_cond,
  output logic            take,
  output tgt_src_e        src,
  output logic            link
);
  logic rs_is_zero;
  logic ops_match;

  assign rs_is_zero = (rs_val == '0);
  assign ops_match  = (rs_val == rt_val);

  always_comb begin
    take = 1'b0;
    src  = SRC_SEQ;
    link = 1'b0;
    case (op)
      OP_BZERO:  begin take = rs_is_zero;  src = SRC_BR; end
      OP_BNZERO: begin take = !rs_is_zero; src = SRC_BR; end
      OP_BSAME:  begin take = ops_match;   src = SRC_BR; end
      OP_BDIFF:  begin take = !ops_match;  src = SRC_BR; end
      OP_BFTRUE: begin take = fp_cond;     src = SRC_BR; end
      OP_BFFALS: begin take = !fp_cond;    src = SRC_BR; end
      OP_JDIR:   begin take = 1'b1; src = SRC_DIR; end
      OP_JREG:   begin take = 1'b1; src = SRC_REG; end
      OP_LDIR:   begin take = 1'b1; src = SRC_DIR; link = 1'b1; end
      OP_LREG:   begin take = 1'b1; src = SRC_REG; link = 1'b1; end
      default:   begin take = 1'b0; src = SRC_SEQ; link = 1'b0; end
    endcase
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN   = 64,
  parameter int BOFF_W = 16,
  parameter int JOFF_W = 26
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [BOFF_W-1:0] boff,
  input  logic [JOFF_W-1:0] joff,
  output logic [XLEN-1:0]   pc4,
  output logic [XLEN-1:0]   br_tgt,
  output logic [XLEN-1:0]   dir_tgt
);
  localparam int INSN_SH  = 2;
  localparam int REGION_W = JOFF_W + INSN_SH;
  localparam int BEXT_W   = XLEN - BOFF_W - INSN_SH;

  logic [XLEN-1:0] br_disp;

  assign pc4     = pc + XLEN'(4);
  assign br_disp = {{BEXT_W{boff[BOFF_W-1]}}, boff, {INSN_SH{1'b0}}};
  assign br_tgt  = pc4 + br_disp;
  assign dir_tgt = {pc4[XLEN-1:REGION_W], joff, {INSN_SH{1'b0}}};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int BOFF_W   = 16,
  parameter int JOFF_W   = 26,
  parameter int LINK_W   = 5,
  parameter int LINK_IDX = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  input  logic              fp_cond,
  input  logic [BOFF_W-1:0] boff,
  input  logic [JOFF_W-1:0] joff,
  output logic              out_valid,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [LINK_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val
);
  localparam int REGION_W = JOFF_W + 2;

  logic            take_w;
  logic            link_w;
  tgt_src_e        src_w;
  logic [XLEN-1:0] pc4_w;
  logic [XLEN-1:0] br_tgt_w;
  logic [XLEN-1:0] dir_tgt_w;
  logic [XLEN-1:0] npc_w;

  npc_cond_eval #(.XLEN(XLEN)) u_cond (
    .op      (op),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .fp_cond (fp_cond),
    .take    (take_w),
    .src     (src_w),
    .link    (link_w)
  );

  npc_target_gen #(.XLEN(XLEN), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W)) u_tgt (
    .pc      (pc),
    .boff    (boff),
    .joff    (joff),
    .pc4     (pc4_w),
    .br_tgt  (br_tgt_w),
    .dir_tgt (dir_tgt_w)
  );

  always_comb begin
    npc_w = pc4_w;
    if (take_w) begin
      case (src_w)
        SRC_BR:  npc_w = br_tgt_w;
        SRC_DIR: npc_w = dir_tgt_w;
        SRC_REG: npc_w = rs_val;
        default: npc_w = pc4_w;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      link_we   <= 1'b0;
      next_pc   <= '0;
      link_val  <= '0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid & take_w;
      link_we   <= in_valid & link_w;
      next_pc   <= npc_w;
      link_val  <= pc4_w;
    end
  end

  assign link_idx = LINK_W'(LINK_IDX);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !taken && !link_we));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !link_we));

  // R3
  seq_next_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SEQ) |=> (next_pc == $past(pc4_w) && !taken));

  // R9
  jreg_target_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_JREG) |=> (next_pc == $past(rs_val) && taken));

  // R10
  link_write_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_LDIR || op == OP_LREG)) |=>
      (link_we && link_val == $past(pc4_w) && link_idx == LINK_W'(LINK_IDX)));

  // R8
  jdir_region_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_JDIR) |=>
      (next_pc[XLEN-1:REGION_W] == $past(pc4_w[XLEN-1:REGION_W]) && next_pc[1:0] == 2'b00));
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [63:0] pc, rs_val, rt_val;
  logic        fp_cond;
  logic [15:0] boff;
  logic [25:0] joff;
  logic        out_valid, taken, link_we;
  logic [63:0] next_pc, link_val;
  logic [4:0]  link_idx;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .pc(pc),
    .rs_val(rs_val), .rt_val(rt_val), .fp_cond(fp_cond), .boff(boff),
    .joff(joff), .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R3";
      4'd1, 4'd2: return "R4/R7";
      4'd3, 4'd4: return "R5/R7";
      4'd5, 4'd6: return "R6/R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9, 4'd10: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic void model(
    input  logic [3:0] o, input logic [63:0] p, input logic [63:0] a,
    input  logic [63:0] b, input logic f, input logic [15:0] bo,
    input  logic [25:0] jo,
    output logic [63:0] nx, output logic tk, output logic lw, output logic [63:0] lv);
    logic [63:0] seq, br, jd;
    logic cond;
    seq  = p + 64'd4;
    br   = seq + ({{48{bo[15]}}, bo} << 2);
    jd   = {seq[63:28], jo, 2'b00};
    cond = 1'b0;
    nx = seq; tk = 1'b0; lw = 1'b0; lv = seq;
    case (o)
      4'd1: cond = (a == 0);
      4'd2: cond = (a != 0);
      4'd3: cond = (a == b);
      4'd4: cond = (a != b);
      4'd5: cond = f;
      4'd6: cond = !f;
      4'd7, 4'd9: begin nx = jd; tk = 1'b1; lw = (o == 4'd9); end
      4'd8, 4'd10: begin nx = a; tk = 1'b1; lw = (o == 4'd10); end
      default: ;
    endcase
    if (o >= 4'd1 && o <= 4'd6 && cond) begin
      nx = br; tk = 1'b1;
    end
  endfunction

  task automatic apply(input logic v, input logic [3:0] o, input logic [63:0] p,
                       input logic [63:0] a, input logic [63:0] b, input logic f,
                       input logic [15:0] bo, input logic [25:0] jo);
    logic [63:0] e_nx, e_lv;
    logic e_tk, e_lw;
    in_valid = v; op = o; pc = p; rs_val = a; rt_val = b;
    fp_cond = f; boff = bo; joff = jo;
    model(o, p, a, b, f, bo, jo, e_nx, e_tk, e_lw, e_lv);
    @(negedge clk);
    n_vec++;
    if (!v) begin
      if (out_valid !== 1'b0 || link_we !== 1'b0) begin
        n_bad++;
        $display("FAIL R11: out_valid=%0b link_we=%0b expected 0 0", out_valid, link_we);
      end
    end else begin
      if (out_valid !== 1'b1 || next_pc !== e_nx || taken !== e_tk || link_we !== e_lw) begin
        n_bad++;
        $display("FAIL %s R2 op=%0d: valid=%0b npc=%h tk=%0b lwe=%0b expected 1 %h %0b %0b",
                 tag_of(o), o, out_valid, next_pc, taken, link_we, e_nx, e_tk, e_lw);
      end else if (e_lw && (link_val !== e_lv || link_idx !== 5'd31)) begin
        n_bad++;
        $display("FAIL R10: link_val=%h idx=%0d expected %h 31", link_val, link_idx, e_lv);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r1, r2, rp;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; op = '0; pc = '0; rs_val = '0; rt_val = '0;
    fp_cond = 1'b0; boff = '0; joff = '0;
    repeat (3) @(negedge clk);
    n_vec++;
    // R1 reset state
    if (out_valid !== 1'b0 || taken !== 1'b0 || link_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: valid=%0b taken=%0b lwe=%0b expected 0 0 0", out_valid, taken, link_we);
    end
    rst = 1'b0;

    // directed corners
    apply(1, 4'd0, 64'h1000, 0, 0, 0, 0, 0);                       // R3
    apply(1, 4'd1, 64'h2000, 0, 5, 0, 16'hFFFF, 0);                // R4 taken, offset -1
    apply(1, 4'd2, 64'h2000, 0, 5, 0, 16'h0010, 0);                // R4 not taken
    apply(1, 4'd3, 64'h3000, 64'hDEAD, 64'hDEAD, 0, 16'h8000, 0);  // R5 most negative
    apply(1, 4'd4, 64'h3000, 64'hDEAD, 64'hDEAD, 0, 16'h7FFF, 0);  // R5 not taken
    apply(1, 4'd5, 64'h4000, 0, 0, 1, 16'h0003, 0);                // R6
    apply(1, 4'd6, 64'h4000, 0, 0, 1, 16'h0003, 0);                // R6 not taken
    apply(1, 4'd1, 64'h0, 0, 0, 0, 16'h8000, 0);                   // R7 wrap below zero
    apply(1, 4'd7, 64'h0000_0000_0FFF_FFFC, 0, 0, 0, 26'h3FFFFFF, 0); // R8 pc+4 crosses region
    apply(1, 4'd7, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0, 0, 0, 26'h1234567); // R8 wrap at top
    apply(1, 4'd8, 64'h5000, 64'hCAFE_0000_1234_5678, 0, 0, 0, 0);   // R9
    apply(1, 4'd9, 64'h6000, 0, 0, 0, 0, 26'h0000ABC);             // R10
    apply(1, 4'd10, 64'h7000, 64'h8000, 0, 0, 0, 0);               // R10
    apply(0, 4'd10, 64'h7000, 64'h8000, 0, 0, 0, 0);               // R11
    for (int c = 11; c < 16; c++) apply(1, 4'(c), 64'h9000, 0, 0, 1, 16'h0040, 26'h40); // R12

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      r1 = {$urandom(), $urandom()};
      r2 = ($urandom_range(0, 3) == 0) ? r1 : {$urandom(), $urandom()};
      if ($urandom_range(0, 4) == 0) r1 = '0;
      rp = {$urandom(), $urandom()};
      rp[1:0] = 2'b00;
      apply($urandom_range(0, 9) != 0, 4'($urandom_range(0, 15)), rp, r1, r2,
            1'($urandom()), 16'($urandom()), 26'($urandom()));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule